// File: doc/BRIEF.md
# Multi-Channel Descriptor DMA Register Front End

This block is the register-access side of a bank of descriptor-driven DMA channels. A host issues word accesses into a 4 KB window. Each access is split into a channel index and a register slot. The block keeps every channel's control word, status word, command pointer and the condition-select words. A write to a channel's control slot updates its status word through a mask that the write carries with it. The block also tells the descriptor sequencer when to fetch a descriptor, when a channel wants to run, and when a flush was requested.

Accesses are handled by a small state machine with four states. `ST_IDLE` waits for a request and holds `req_ready` high. From there, a well-formed read goes to `ST_READ`, a well-formed write goes to `ST_WRITE`, and a request with a bad size or bad alignment goes to `ST_REJECT`. Each of the three operating states lasts one cycle and then returns unconditionally to `ST_IDLE`. The registered response is presented during that return cycle.

Top module: `dmachan_regfile`

## Requirements
- R1: Address bits [11:7] select one of 32 channels. Address bits [6:2] select a word slot inside the channel. Slot 0 is control, 1 is status, 3 is command pointer low, and 5 is branch select.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the next cycle. `rsp_valid` is high for exactly one cycle after the second edge. `rsp_rdata` is zero on write responses.
- R3: A control write uses bits [31:16] as a mask M and bits [15:0] as a value V. The status becomes ((V AND 0xF0FF) AND M) OR (old AND NOT M). Status bit positions are: run 15, pause 14, flush 13, wake 12, dead 11, active 10, and device status 7:0. A masked bit outside 0xF0FF is therefore cleared.
- R4: If a control write takes run from 0 to 1, active is set. If it takes run from 1 to 0, active and dead are cleared.
- R5: A control write that leaves the flush bit set produces a one-cycle `flush_pulse`, with `flush_ch` naming the channel.
- R6: A write to command pointer low is ignored while run or active is set. The readback is unchanged and no fetch pulse is produced.
- R7: An accepted command-pointer-low write stores the value with bits [3:0] forced to zero. It also produces a one-cycle `fetch_pulse` carrying the channel and the aligned pointer.
- R8: Reset clears every register of every channel to zero.
- R9: A request that is not word sized is rejected. Size code 2 means 4 bytes; codes 0, 1 and 3 are rejected. A request whose address bits [1:0] are nonzero is also rejected. A rejected request changes no register, returns zero data, and raises `bus_err` for one cycle.
- R10: `run_req[i]` is high exactly when channel i has both run and active set and `proc_busy[i]` is low.
- R11: A direct write to the status slot is ignored. The other slots, including control, read back the last word written to them.
- R12: Slots 16 to 31 of a channel read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (2 = 4 bytes) |
| req_addr | input | 12 | Byte address in the window |
| req_wdata | input | 32 | Write data (little-endian word) |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data |
| bus_err | output | 1 | Rejected access |
| fetch_pulse | output | 1 | Descriptor fetch request |
| fetch_ch | output | 5 | Channel to fetch for |
| fetch_ptr | output | 32 | Aligned descriptor address |
| flush_pulse | output | 1 | Flush request |
| flush_ch | output | 5 | Channel asking for flush |
| proc_busy | input | 32 | Sequencer already processing channel i |
| run_req | output | 32 | Channel i wants to run |

## Verification
The bench aims at the command-pointer interlock. A design that ignored the busy state would let a pointer write while running overwrite the readback and emit a fetch. It checks that a masked control write clears the active bit even though that bit cannot be set by a value. A design that masked the mask as well as the value would leave active set. It drives run falling and rising to catch a missed active clear or set, and a missing or wrongly-addressed flush pulse. It sends odd sizes, misaligned addresses and slots past the implemented range. A design that decoded these anyway would corrupt a neighbouring slot or return stale data.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // status word bit positions (decoded by the sequencer)
    localparam int BIT_RUN    = 15;
    localparam int BIT_PAUSE  = 14;
    localparam int BIT_FLUSH  = 13;
    localparam int BIT_WAKE   = 12;
    localparam int BIT_DEAD   = 11;
    localparam int BIT_ACTIVE = 10;

    localparam logic [HALF_W-1:0] CTL_WRITABLE =
        HALF_W'((1 << BIT_RUN) | (1 << BIT_PAUSE) | (1 << BIT_FLUSH) |
                (1 << BIT_WAKE) | 16'h00FF);

    // slot numbers that carry behaviour
    localparam int SLOT_CTRL   = 0;
    localparam int SLOT_STAT   = 1;
    localparam int SLOT_PTR_LO = 3;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_REJECT
    } acc_state_e;

endpackage

// File: rtl/dmachan_decode.sv
module dmachan_decode #(
    parameter int NUM_CH   = 32,
    parameter int CH_BYTES = 128,
    parameter int REGS     = 16,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int SLOT_W   = $clog2(CH_BYTES) - 2,
    parameter int REG_W    = $clog2(REGS)
) (
    input  logic [CH_W+SLOT_W-1:0] word_addr,
    output logic [CH_W-1:0]        ch_idx,
    output logic [REG_W-1:0]       slot,
    output logic                   in_range
);

    logic [SLOT_W-1:0] word_slot;

    assign ch_idx    = word_addr[CH_W+SLOT_W-1:SLOT_W];
    assign word_slot = word_addr[SLOT_W-1:0];
    assign slot      = word_slot[REG_W-1:0];
    assign in_range  = (int'(word_slot) < REGS);

endmodule

// File: rtl/dmachan_channel.sv
module dmachan_channel
    import dmachan_pkg::*;
#(
    parameter int REGS  = 16,
    parameter int REG_W = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  slot,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [HALF_W-1:0] stat_o,
    output logic              fetch_evt,
    output logic              flush_evt
);

    logic [WORD_W-1:0] slot_q [REGS];
    logic [HALF_W-1:0] stat_q;
    logic [HALF_W-1:0] ctl_mask, ctl_val, stat_mix, stat_next;
    logic              is_ctl, is_stat, is_ptr, busy;
    logic              ctl_hit, ptr_hit, plain_hit;

    assign is_ctl  = (slot == REG_W'(SLOT_CTRL));
    assign is_stat = (slot == REG_W'(SLOT_STAT));
    assign is_ptr  = (slot == REG_W'(SLOT_PTR_LO));
    assign busy    = stat_q[BIT_RUN] | stat_q[BIT_ACTIVE];

    always_comb begin
        ctl_mask  = wr_data[WORD_W-1:HALF_W];
        ctl_val   = wr_data[HALF_W-1:0] & CTL_WRITABLE;
        stat_mix  = (ctl_val & ctl_mask) | (stat_q & ~ctl_mask);
        stat_next = stat_mix;
        if (stat_q[BIT_RUN] && !stat_mix[BIT_RUN]) begin
            stat_next[BIT_ACTIVE] = 1'b0;
            stat_next[BIT_DEAD]   = 1'b0;
        end else if (!stat_q[BIT_RUN] && stat_mix[BIT_RUN]) begin
            stat_next[BIT_ACTIVE] = 1'b1;
        end
    end

    assign ctl_hit   = wr_en && is_ctl;
    assign ptr_hit   = wr_en && is_ptr && !busy;
    assign plain_hit = wr_en && !is_stat && !is_ptr;

    assign fetch_evt = ptr_hit;
    assign flush_evt = ctl_hit && stat_next[BIT_FLUSH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            for (int i = 0; i < REGS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            if (ctl_hit) begin
                stat_q <= stat_next;
            end
            if (ptr_hit) begin
                slot_q[SLOT_PTR_LO] <= {wr_data[WORD_W-1:4], 4'h0};
            end
            if (plain_hit) begin
                slot_q[slot] <= wr_data;
            end
        end
    end

    assign rd_data = is_stat ? {{(WORD_W-HALF_W){1'b0}}, stat_q} : slot_q[slot];
    assign stat_o  = stat_q;

endmodule

// File: rtl/dmachan_access_fsm.sv
module dmachan_access_fsm
    import dmachan_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              req_ready,
    output logic              wr_fire,
    output logic [ADDR_W-3:0] lat_word,
    output logic [WORD_W-1:0] lat_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              bus_err
);

    acc_state_e state_q, state_d;
    logic       well_formed;

    assign well_formed = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!well_formed)   state_d = ST_REJECT;
                    else if (req_write) state_d = ST_WRITE;
                    else                state_d = ST_READ;
                end
            end
            ST_READ:   state_d = ST_IDLE;
            ST_WRITE:  state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_word  <= '0;
            lat_wdata <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            lat_word  <= req_addr[ADDR_W-1:2];
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            rsp_valid <= (state_q != ST_IDLE);
            rsp_rdata <= (state_q == ST_READ) ? rd_data_i : '0;
            bus_err   <= (state_q == ST_REJECT);
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign wr_fire   = (state_q == ST_WRITE);

endmodule

// File: rtl/dmachan_regfile.sv
module dmachan_regfile
    import dmachan_pkg::*;
#(
    parameter int NUM_CH   = 32,
    parameter int CH_BYTES = 128,
    parameter int REGS     = 16,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int ADDR_W   = $clog2(NUM_CH * CH_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              bus_err,
    output logic              fetch_pulse,
    output logic [CH_W-1:0]   fetch_ch,
    output logic [31:0]       fetch_ptr,
    output logic              flush_pulse,
    output logic [CH_W-1:0]   flush_ch,
    input  logic [NUM_CH-1:0] proc_busy,
    output logic [NUM_CH-1:0] run_req
);

    localparam int SLOT_W = $clog2(CH_BYTES) - 2;
    localparam int REG_W  = $clog2(REGS);

    logic              wr_fire;
    logic [ADDR_W-3:0] lat_word;
    logic [31:0]       lat_wdata;
    logic [31:0]       rd_mux;
    logic [CH_W-1:0]   ch_idx;
    logic [REG_W-1:0]  slot;
    logic              in_range;

    logic [31:0]       ch_rd   [NUM_CH];
    logic [15:0]       ch_stat [NUM_CH];
    logic [NUM_CH-1:0] fetch_vec, flush_vec;

    dmachan_access_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data_i (rd_mux),
        .req_ready (req_ready),
        .wr_fire   (wr_fire),
        .lat_word  (lat_word),
        .lat_wdata (lat_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .bus_err   (bus_err)
    );

    dmachan_decode #(
        .NUM_CH(NUM_CH), .CH_BYTES(CH_BYTES), .REGS(REGS)
    ) u_dec (
        .word_addr (lat_word),
        .ch_idx    (ch_idx),
        .slot      (slot),
        .in_range  (in_range)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr_fire && in_range && (ch_idx == CH_W'(g));

        dmachan_channel #(.REGS(REGS)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel),
            .slot      (slot),
            .wr_data   (lat_wdata),
            .rd_data   (ch_rd[g]),
            .stat_o    (ch_stat[g]),
            .fetch_evt (fetch_vec[g]),
            .flush_evt (flush_vec[g])
        );

        assign run_req[g] = ch_stat[g][BIT_RUN] & ch_stat[g][BIT_ACTIVE] & ~proc_busy[g];
    end

    assign rd_mux = in_range ? ch_rd[ch_idx] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pulse <= 1'b0;
            fetch_ch    <= '0;
            fetch_ptr   <= '0;
            flush_pulse <= 1'b0;
            flush_ch    <= '0;
        end else begin
            fetch_pulse <= |fetch_vec;
            flush_pulse <= |flush_vec;
            if (|fetch_vec) begin
                fetch_ch  <= ch_idx;
                fetch_ptr <= {lat_wdata[31:4], 4'h0};
            end
            if (|flush_vec) begin
                flush_ch <= ch_idx;
            end
        end
    end

endmodule

// File: rtl/dmachan_regfile_chk.sv
module dmachan_regfile_chk #(
    parameter int NUM_CH = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              bus_err,
    input logic              fetch_pulse,
    input logic [31:0]       fetch_ptr,
    input logic              flush_pulse,
    input logic [NUM_CH-1:0] proc_busy,
    input logic [NUM_CH-1:0] run_req
);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R2
    resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> ##1 rsp_valid);

    // R9
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> rsp_valid && rsp_rdata == 32'h0);

    // R7
    fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_pulse |-> rsp_valid && fetch_ptr[3:0] == 4'h0 && !bus_err);

    // R5
    flush_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> rsp_valid && !bus_err);

    // R10
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req & proc_busy) == '0);

endmodule

bind dmachan_regfile dmachan_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .bus_err     (bus_err),
    .fetch_pulse (fetch_pulse),
    .fetch_ptr   (fetch_ptr),
    .flush_pulse (flush_pulse),
    .proc_busy   (proc_busy),
    .run_req     (run_req)
);

// File: tb/dmachan_regfile_bench.sv
module dmachan_regfile_bench;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        f;
        logic        fl;
        logic        er;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 12'h184, 32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 4'd8},  // R8
        '{1'b1, 2'd2, 12'h18C, 32'h00001237, 32'h0,        1'b1, 1'b0, 1'b0, 4'd7},  // R7
        '{1'b0, 2'd2, 12'h18C, 32'h0,        32'h00001230, 1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b1, 2'd2, 12'h180, 32'h80FF8012, 32'h0,        1'b0, 1'b0, 1'b0, 4'd3},  // R3 R4
        '{1'b0, 2'd2, 12'h184, 32'h0,        32'h00008412, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 2'd2, 12'h18C, 32'h00005550, 32'h0,        1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{1'b0, 2'd2, 12'h18C, 32'h0,        32'h00001230, 1'b0, 1'b0, 1'b0, 4'd6},
        '{1'b1, 2'd2, 12'h180, 32'hA0002000, 32'h0,        1'b0, 1'b1, 1'b0, 4'd5},  // R5 R4
        '{1'b0, 2'd2, 12'h184, 32'h0,        32'h00002012, 1'b0, 1'b0, 1'b0, 4'd4},
        '{1'b1, 2'd2, 12'h18C, 32'hFFFFFFFF, 32'h0,        1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, 2'd2, 12'h18C, 32'h0,        32'hFFFFFFF0, 1'b0, 1'b0, 1'b0, 4'd7},
        '{1'b1, 2'd2, 12'h184, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b0, 1'b0, 4'd11}, // R11
        '{1'b0, 2'd2, 12'h184, 32'h0,        32'h00002012, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 2'd2, 12'hF94, 32'h000F0005, 32'h0,        1'b0, 1'b0, 1'b0, 4'd1},  // R1
        '{1'b0, 2'd2, 12'hF94, 32'h0,        32'h000F0005, 1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b0, 2'd2, 12'h194, 32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 4'd1},
        '{1'b1, 2'd1, 12'hF94, 32'h00001234, 32'h0,        1'b0, 1'b0, 1'b1, 4'd9},  // R9
        '{1'b0, 2'd2, 12'hF94, 32'h0,        32'h000F0005, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b0, 2'd0, 12'hF94, 32'h0,        32'h0,        1'b0, 1'b0, 1'b1, 4'd9},
        '{1'b1, 2'd2, 12'hFC0, 32'h0000DEAD, 32'h0,        1'b0, 1'b0, 1'b0, 4'd12}, // R12
        '{1'b0, 2'd2, 12'hFC0, 32'h0,        32'h0,        1'b0, 1'b0, 1'b0, 4'd12},
        '{1'b1, 2'd2, 12'hF80, 32'hFFFFFFFF, 32'h0,        1'b0, 1'b1, 1'b0, 4'd3},  // R3
        '{1'b0, 2'd2, 12'hF84, 32'h0,        32'h0000F4FF, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 2'd2, 12'hF80, 32'h04000000, 32'h0,        1'b0, 1'b1, 1'b0, 4'd3},
        '{1'b0, 2'd2, 12'hF84, 32'h0,        32'h0000F0FF, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b0, 2'd2, 12'hF80, 32'h0,        32'h04000000, 1'b0, 1'b0, 1'b0, 4'd11},
        '{1'b1, 2'd2, 12'hF96, 32'h11111111, 32'h0,        1'b0, 1'b0, 1'b1, 4'd9},
        '{1'b0, 2'd2, 12'hF94, 32'h0,        32'h000F0005, 1'b0, 1'b0, 1'b0, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_size;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        req_ready, rsp_valid, bus_err, fetch_pulse, flush_pulse;
    logic [31:0] rsp_rdata, fetch_ptr;
    logic [4:0]  fetch_ch, flush_ch;
    logic [31:0] proc_busy, run_req;

    int n_chk = 0;
    int n_bad = 0;

    logic        mid_ready, mid_rv, c_rv, c_f, c_fl, c_er;
    logic [31:0] c_rd, c_fptr, c_run;
    logic [4:0]  c_fch, c_flch;

    always #5 clk = ~clk;

    dmachan_regfile u_dmachan_regfile (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_ready (req_ready),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .bus_err (bus_err),
        .fetch_pulse (fetch_pulse), .fetch_ch (fetch_ch), .fetch_ptr (fetch_ptr),
        .flush_pulse (flush_pulse), .flush_ch (flush_ch),
        .proc_busy (proc_busy), .run_req (run_req)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        mid_ready = req_ready;
        mid_rv    = rsp_valid;
        @(negedge clk);
        c_rv = rsp_valid; c_rd = rsp_rdata; c_f = fetch_pulse; c_fl = flush_pulse;
        c_er = bus_err; c_fch = fetch_ch; c_fptr = fetch_ptr; c_flch = flush_ch; c_run = run_req;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2;
        req_addr = '0; req_wdata = '0; proc_busy = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state at the ports
        check(req_ready && !rsp_valid && !fetch_pulse && !flush_pulse && run_req == 0,
              "R8 reset outputs", {31'b0, req_ready, run_req}, {31'b0, 1'b1, 32'h0});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            access(v.wr, v.sz, v.addr, v.wd);
            check(c_rv && c_rd == v.exp && c_f == v.f && c_fl == v.fl && c_er == v.er,
                  $sformatf("R%0d vec%0d rd/f/fl/er", v.rq, i),
                  {c_rd, 29'b0, c_f, c_fl, c_er}, {v.exp, 29'b0, v.f, v.fl, v.er});
        end

        // R2 one-cycle gap then response
        check(!mid_ready && !mid_rv && c_rv, "R2 ready/valid timing",
              {61'b0, mid_ready, mid_rv, c_rv}, {61'b0, 3'b001});

        // R10 run without active does not request
        check(c_run == 32'h0, "R10 run only", {32'b0, c_run}, 64'h0);

        // R4 R5 run falling keeps flush, pulse names channel 31
        access(1'b1, 2'd2, 12'hF80, 32'h80000000);
        check(c_fl && c_flch == 5'd31, "R5 flush channel", {58'b0, c_fl, c_flch}, {58'b0, 1'b1, 5'd31});
        access(1'b0, 2'd2, 12'hF84, 32'h0);
        check(c_rd == 32'h000070FF, "R4 run fall", {32'b0, c_rd}, 64'h70FF);

        // R4 run rising sets active; R10 request and gating
        access(1'b1, 2'd2, 12'hF80, 32'h80008000);
        check(c_run == 32'h80000000, "R10 run_req ch31", {32'b0, c_run}, 64'h80000000);
        @(negedge clk);
        proc_busy = 32'h80000000;
        #1;
        check(run_req == 32'h0, "R10 busy gate", {32'b0, run_req}, 64'h0);
        proc_busy = '0;

        // R7 fetch carries channel and aligned pointer
        access(1'b1, 2'd2, 12'h28C, 32'h0000ABCD);
        check(c_f && c_fch == 5'd5 && c_fptr == 32'h0000ABC0, "R7 fetch ch/ptr",
              {26'b0, c_f, c_fch, c_fptr}, {26'b0, 1'b1, 5'd5, 32'h0000ABC0});

        // R8 reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(run_req == 32'h0 && req_ready, "R8 reset run_req", {31'b0, req_ready, run_req}, {31'b0, 1'b1, 32'h0});
        access(1'b0, 2'd2, 12'hF84, 32'h0);
        check(c_rd == 32'h0, "R8 status cleared", {32'b0, c_rd}, 64'h0);
        access(1'b0, 2'd2, 12'hF94, 32'h0);
        check(c_rd == 32'h0, "R8 select cleared", {32'b0, c_rd}, 64'h0);

        finish_run();
    end

endmodule